// File: doc/BRIEF.md
# Sampling ADC conversion sequencer

This block sequences one conversion of a successive-approximation converter from a single fast clock. An active-low start strobe arrives with no timing relation to that clock, so the block resynchronises it. The strobe counts only if it stays low long enough. When it rises, the block switches the track/hold stage to hold and begins stepping through the conversion. While a valid strobe is low, an active-low busy line acknowledges it. Busy follows the strobe itself, not the whole conversion.

A host bus may access the converter during the clock-low phase. Each such access takes one conversion step away, so the conversion runs one cycle longer for every access. The analog side is represented by a single comparator-decision input. The block resolves one result bit per group of steps, starting with the most significant bit. It then offers the finished code on a valid/ready output port. The result is held under back-pressure, and the block will not return to tracking until the code has been taken. Start strobes are ignored until that handshake completes.

Top module: `adc_conv_seq`

## Requirements
- R1: While `rst_n` is low and after it is released, `busy_n` is 1, `hold` is 0, `step_count` is 0 and `res_valid` is 0.
- R2: `start_n` passes through a two-flop synchroniser. A low pulse counts only if it is sampled low on at least MIN_LOW (2) consecutive clock edges while the block is tracking. A shorter pulse changes neither `busy_n` nor `hold`.
- R3: `busy_n` goes low once a qualifying low strobe has been seen while tracking. It returns high once the conversion starts, and it stays high throughout the conversion and while a result is pending.
- R4: After a qualifying strobe, `hold` rises on the third rising clock edge after `start_n` rises. At that point `step_count` restarts from 0.
- R5: A conversion is BASE_CYCLES (56) non-stalled cycles long. `step_count` advances by one on each of those cycles, ends at 56, and holds 56 until the next conversion starts.
- R6: Each cycle in which `host_access` is 1 during hold freezes `step_count` for that cycle. `hold` therefore stays high for 56 plus the number of such cycles; 17 accesses give 73 cycles. `host_access` has no effect while tracking.
- R7: A start strobe that goes low during a conversion or while a result is pending never starts a conversion. Low cycles are counted only while tracking.
- R8: Result bit 11-k is taken from `cmp_bit` on the edge that ends step count 4k+3, for k = 0 to 11. The most significant bit is taken first.
- R9: On the edge where `hold` falls, `res_valid` rises, and `res_data` carries the resolved 12-bit code.
- R10: `res_valid` and `res_data` stay unchanged until `res_ready` is sampled high. On the following edge `res_valid` drops and the block returns to tracking, where a new start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low reset |
| start_n | input | 1 | Asynchronous active-low conversion-start strobe |
| host_access | input | 1 | One host access overlapping the clock-low phase this cycle |
| cmp_bit | input | 1 | Comparator decision for the current trial bit |
| busy_n | output | 1 | Active-low acknowledge of a received start strobe |
| hold | output | 1 | 1 = track/hold in hold mode (conversion running) |
| step_count | output | 6 | Non-stalled conversion steps completed |
| res_valid | output | 1 | Result word available |
| res_ready | input | 1 | Downstream accepts the result |
| res_data | output | 12 | Converted code |

## Verification
On every cycle, the bound checker tracks the step counter. It confirms that the counter freezes on an access cycle and advances on any other cycle while holding. It also checks that the result stays stable under back-pressure, that busy never overlaps hold or a pending result, and that hold never rises without a prior busy acknowledge. Other behaviour needs the bench's scenarios, because it depends on history or arithmetic over a whole conversion. These scenarios cover the rejection of one-cycle strobes, the three-edge start latency, and conversion length as a function of access count (swept from 0 to 17). They also cover the bit-by-bit code value across a sweep of codes, and the rejection of strobes issued during a conversion or a pending result.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_TRACK = 2'd0,
    ST_CONV  = 2'd1,
    ST_DONE  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/adc_start_qual.sv
// Resynchronises the start strobe and qualifies its low width.
module adc_start_qual #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_LOW     = 2,
  localparam int LW = $clog2(MIN_LOW + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_n,
  input  logic enable,
  output logic armed,
  output logic start_ok
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic [LW-1:0]          low_cnt;
  logic                   synced;

  assign synced = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '1;
      prev_q  <= 1'b1;
      low_cnt <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], start_n};
      prev_q <= synced;
      if (!enable || synced)
        low_cnt <= '0;
      else if (low_cnt < LW'(MIN_LOW))
        low_cnt <= low_cnt + 1'b1;
    end
  end

  assign armed    = enable && (low_cnt == LW'(MIN_LOW));
  assign start_ok = armed && synced && !prev_q;
endmodule

// File: rtl/adc_step_ctr.sv
// Counts non-stalled conversion steps.
module adc_step_ctr #(
  parameter int BASE_CYCLES = 56,
  localparam int CW = $clog2(BASE_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  output logic [CW-1:0] count,
  output logic          last
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else if (adv) count <= count + 1'b1;
  end

  assign last = (count == CW'(BASE_CYCLES - 1));
endmodule

// File: rtl/adc_sar_reg.sv
// Successive-approximation register: one bit per SPAN steps, MSB first.
module adc_sar_reg #(
  parameter int RES_BITS    = 12,
  parameter int BASE_CYCLES = 56,
  localparam int SPAN = BASE_CYCLES / RES_BITS,
  localparam int PW   = (SPAN > 1) ? $clog2(SPAN) : 1,
  localparam int IW   = $clog2(RES_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                adv,
  input  logic                cmp_bit,
  output logic [RES_BITS-1:0] code
);
  logic [PW-1:0] phase;
  logic [IW-1:0] idx;
  logic          take;

  assign take = adv && (phase == PW'(SPAN - 1)) && (idx < IW'(RES_BITS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      idx   <= '0;
    end else if (clr) begin
      phase <= '0;
      idx   <= '0;
    end else if (adv) begin
      phase <= (phase == PW'(SPAN - 1)) ? '0 : phase + 1'b1;
      if (take) idx <= idx + 1'b1;
    end
  end

  for (genvar b = 0; b < RES_BITS; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        code[b] <= 1'b0;
      else if (clr)
        code[b] <= 1'b0;
      else if (take && (idx == IW'(RES_BITS - 1 - b)))
        code[b] <= cmp_bit;
    end
  end
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_seq_pkg::*;
#(
  parameter int RES_BITS    = 12,
  parameter int BASE_CYCLES = 56,
  parameter int MIN_LOW     = 2,
  parameter int SYNC_STAGES = 2,
  localparam int CW = $clog2(BASE_CYCLES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_n,
  input  logic                host_access,
  input  logic                cmp_bit,
  output logic                busy_n,
  output logic                hold,
  output logic [CW-1:0]       step_count,
  output logic                res_valid,
  input  logic                res_ready,
  output logic [RES_BITS-1:0] res_data
);
  seq_state_t state_q, state_d;
  logic armed, start_ok, adv, last;

  adc_start_qual #(.SYNC_STAGES(SYNC_STAGES), .MIN_LOW(MIN_LOW)) u_qual (
    .clk(clk), .rst_n(rst_n), .start_n(start_n),
    .enable(state_q == ST_TRACK), .armed(armed), .start_ok(start_ok)
  );

  assign adv = (state_q == ST_CONV) && !host_access;

  adc_step_ctr #(.BASE_CYCLES(BASE_CYCLES)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clr(start_ok), .adv(adv),
    .count(step_count), .last(last)
  );

  adc_sar_reg #(.RES_BITS(RES_BITS), .BASE_CYCLES(BASE_CYCLES)) u_sar (
    .clk(clk), .rst_n(rst_n), .clr(start_ok), .adv(adv),
    .cmp_bit(cmp_bit), .code(res_data)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_TRACK: if (start_ok)    state_d = ST_CONV;
      ST_CONV:  if (adv && last) state_d = ST_DONE;
      ST_DONE:  if (res_ready)   state_d = ST_TRACK;
      default:                   state_d = ST_TRACK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_TRACK;
    else        state_q <= state_d;
  end

  assign busy_n    = !armed;
  assign hold      = (state_q == ST_CONV);
  assign res_valid = (state_q == ST_DONE);
endmodule

// File: rtl/adc_conv_seq_chk.sv
module adc_conv_seq_chk #(
  parameter int RES_BITS    = 12,
  parameter int BASE_CYCLES = 56,
  localparam int CW = $clog2(BASE_CYCLES + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                host_access,
  input logic                busy_n,
  input logic                hold,
  input logic [CW-1:0]       step_count,
  input logic                res_valid,
  input logic                res_ready,
  input logic [RES_BITS-1:0] res_data
);
  a_r3_busy_clear_in_conv: assert property (@(posedge clk) disable iff (!rst_n)
    (hold || res_valid) |-> busy_n);
  a_r4_hold_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold) |-> $past(!busy_n));
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    step_count <= CW'(BASE_CYCLES));
  a_r6_stall_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && host_access) |=> (hold && $stable(step_count)));
  a_r5_step_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !host_access) |=> (step_count == CW'($past(step_count) + 1'b1)));
  a_r9_valid_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> res_valid);
  a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(hold && res_valid));
  a_r10_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));
  a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> !res_valid);
endmodule

bind adc_conv_seq adc_conv_seq_chk #(.RES_BITS(RES_BITS), .BASE_CYCLES(BASE_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_access(host_access), .busy_n(busy_n),
  .hold(hold), .step_count(step_count), .res_valid(res_valid),
  .res_ready(res_ready), .res_data(res_data)
);

// File: tb/sim_adc_conv_seq.sv
`timescale 1ns/1ps
module sim_adc_conv_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_n = 1'b1, host_access = 1'b0, cmp_bit, res_ready = 1'b0;
  logic busy_n, hold, res_valid;
  logic [5:0]  step_count;
  logic [11:0] res_data;
  logic [11:0] target = '0;
  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  adc_conv_seq u0 (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .host_access(host_access),
    .cmp_bit(cmp_bit), .busy_n(busy_n), .hold(hold), .step_count(step_count),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data)
  );

  // R8: comparator decision for step count 4k+3 is bit 11-k of the target.
  always_comb begin
    int k;
    k = int'(step_count) / 4;
    cmp_bit = (k < 12) ? target[11 - k] : 1'b0;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // Drive a strobe low for len cycles; report busy_n low seen and hold latency.
  task automatic pulse(input int len, output bit busy_seen, output int lat);
    busy_seen = 0;
    lat = -1;
    start_n = 1'b0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (!busy_n) busy_seen = 1;
    end
    start_n = 1'b1;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      if (!busy_n) busy_seen = 1;
      if (hold && lat < 0) begin
        lat = k;
        break;
      end
    end
  endtask

  task automatic run_conv(input logic [11:0] code, input int n_acc, input int rdy_delay,
                          input bit mid_start);
    bit bs;
    int lat, cycles, exp_cnt, given, bad_cnt, busy_bad;
    logic [11:0] d0;
    target = code;
    pulse(2 + (n_acc % 3), bs, lat);
    check(bs, "R3 busy_n low on valid strobe", int'(bs), 1);
    check(lat == 3, "R4 hold latency", lat, 3);
    check(step_count == 0, "R4 count restart", int'(step_count), 0);
    cycles = 0; exp_cnt = 0; given = 0; bad_cnt = 0; busy_bad = 0;
    while (hold === 1'b1 && cycles < 200) begin
      if (step_count != 6'(exp_cnt)) bad_cnt++;
      if (!busy_n) busy_bad++;
      cycles++;
      host_access = (cycles % 3 == 1) && (given < n_acc);
      if (host_access) given++; else exp_cnt++;
      if (mid_start) start_n = !(cycles >= 5 && cycles < 9);
      @(negedge clk);
    end
    host_access = 1'b0;
    start_n = 1'b1;
    check(bad_cnt == 0, "R6 count freezes on access", bad_cnt, 0);
    check(busy_bad == 0, "R3 busy_n high in conversion", busy_bad, 0);
    check(cycles == 56 + n_acc, "R6 stretched length", cycles, 56 + n_acc);
    check(step_count == 56, "R5 final step count", int'(step_count), 56);
    check(res_valid == 1'b1, "R9 valid at end", int'(res_valid), 1);
    check(res_data == code, "R8 resolved code", int'(res_data), int'(code));
    d0 = res_data;
    for (int i = 0; i < rdy_delay; i++) begin
      if (rdy_delay >= 6) start_n = !(i < 3);   // R7 strobe while pending
      @(negedge clk);
    end
    start_n = 1'b1;
    check(res_valid && res_data == d0, "R10 held under back-pressure", int'(res_data), int'(d0));
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    check(!res_valid, "R10 valid drops after accept", int'(res_valid), 0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (hold) busy_bad++;
    end
    check(busy_bad == 0 && busy_n, "R7 ignored strobes start nothing", busy_bad, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    finish_up();
  end

  initial begin
    bit bs;
    int lat;
    // R1 reset state
    repeat (3) @(negedge clk);
    check(busy_n && !hold && step_count == 0 && !res_valid, "R1 reset state",
          int'({busy_n, hold, res_valid}), 4);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy_n && !hold && step_count == 0 && !res_valid, "R1 after release",
          int'({busy_n, hold, res_valid}), 4);
    // R6: access while tracking has no effect
    host_access = 1'b1;
    repeat (4) @(negedge clk);
    host_access = 1'b0;
    check(!hold && step_count == 0, "R6 access while tracking", int'(step_count), 0);
    // R2: one-cycle strobe ignored
    pulse(1, bs, lat);
    check(!bs && lat < 0, "R2 short strobe ignored", lat, -1);
    // Sweep codes and access counts
    for (int i = 0; i < 28; i++) begin
      logic [11:0] code;
      if (i < 12)       code = 12'(1) << i;
      else if (i == 12) code = 12'h000;
      else if (i == 13) code = 12'hFFF;
      else              code = 12'(i * 2487) ^ 12'h3C1;
      run_conv(code, i % 18, (i % 4) * 3, (i % 5) == 2);
    end
    run_conv(12'hA5A, 17, 7, 1'b1);
    finish_up();
  end
endmodule